// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block receives one asynchronous serial channel in the system clock domain. The bit time is set in clocks by a configuration input. A start edge on the synchronized line opens a frame. Each bit slot is then sampled at a configurable fraction of the bit time, and the data bits are assembled in the selected order. The start field, the optional parity field and the stop fields are each checked. When a frame finishes, the block gives a one-clock strobe that carries the data word and its error flags.

The same line is also watched for two conditions outside a frame. A break is a low level that lasts at least a programmed number of clocks. Idle is a high level that lasts a whole frame time. Each condition gives a single-clock pulse. The frame format is captured when a frame starts, so a change to the format inputs in the middle of a frame has no effect on that frame. A new start edge is accepted only after the full length of the previous frame has passed.

Top module: `uart_frame_rx`

## Requirements
- R1: With `cfg_invert`=0 a falling edge of the synchronized line starts a frame while the receiver is idle. With `cfg_invert`=1 a rising edge starts a frame and all sampled levels are complemented.
- R2: Counting clocks from the start edge, bit slot k (0 = start, then data, then parity, then stop) is sampled at k*B + ceil((B-1)*P/100). B is the bit time and P is `cfg_sample_pct`. A P outside 1..99, including 0, acts as 50.
- R3: A start slot that samples high is rejected. `rx_frame_err` pulses for one clock with `rx_valid` low, and the receiver returns to idle.
- R4: `cfg_data_bits` selects 5 to 9 data bits. Values below 5 act as 5 and values above 9 act as 9. `cfg_msb_first`=0 takes the first data bit as bit 0, and 1 takes it as the top bit. Unused upper bits of `rx_data` read 0.
- R5: `cfg_parity` codes are 0 none, 1 odd, 2 even, 3 bit must be 0, 4 bit must be 1, 5 ignore, and 6 or 7 act as none. A mismatch sets `rx_parity_err` on the strobe but the data is still delivered. Ignore never flags an error, and none has no parity slot.
- R6: `cfg_stop_bits` gives 0, 1 or 2 stop slots, and 3 acts as 2. Any stop slot that samples low sets `rx_frame_err` on the strobe. All stop slots are sampled before the strobe is given.
- R7: Each accepted frame gives exactly one `rx_valid` pulse, one clock wide, with `rx_data`, `rx_frame_err` and `rx_parity_err` valid in the same clock.
- R8: After the last sample of a frame, a start edge is not accepted until the frame's full length of slots × B clocks has passed since its start edge.
- R9: When `cfg_break_clks` is nonzero and the line stays low for that many clocks, `brk_pulse` goes high for one clock, once per low stretch. Any frame in progress is abandoned with no strobe. A value of 0 turns break detection off.
- R10: While the receiver is idle and the line is high, `idle_pulse` goes high once per full frame length of the current format. The interval starts again after each pulse and after each frame.
- R11: The format inputs (data bits, parity, stop bits, order, bit time, sample point) are captured at the start edge. Changes during a frame do not affect it.
- R12: After reset every output is 0.
- R13: `cfg_clks_per_bit` sets B. Values below 4 act as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input |
| cfg_invert | input | 1 | Complement the line level |
| cfg_clks_per_bit | input | CPB_W | Bit time in clocks |
| cfg_data_bits | input | 4 | Data bits per frame (5..9) |
| cfg_parity | input | 3 | Parity mode code |
| cfg_stop_bits | input | 2 | Stop slot count |
| cfg_msb_first | input | 1 | Data bit order |
| cfg_sample_pct | input | 7 | Sample point in percent of the bit |
| cfg_break_clks | input | BRK_W | Minimum low time for a break, 0 = off |
| rx_valid | output | 1 | One-clock frame strobe |
| rx_data | output | 9 | Received data word |
| rx_frame_err | output | 1 | Start or stop field error |
| rx_parity_err | output | 1 | Parity mismatch on the strobe |
| brk_pulse | output | 1 | Break detected |
| idle_pulse | output | 1 | Line idle for one frame length |

## Verification
The bench sweeps every data width, parity code, stop count and bit order. A slip in how fields are ordered or skipped would show up as shifted data or a spurious frame error. Sample-point cases put a level change mid-slot, so that settings just either side of it, and the fallback values, pick different halves. An off-by-one in the offset formula would therefore read the wrong value. A short glitch just before the end of a frame catches a receiver that restarts too early, because that receiver would report a rejected start. Long low stretches, one shorter than a frame and one past the break limit, show whether a break aborts a frame and whether it pulses only once.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DMAX = 9;

    typedef enum logic [2:0] {
        PAR_NONE   = 3'd0,
        PAR_ODD    = 3'd1,
        PAR_EVEN   = 3'd2,
        PAR_ZERO   = 3'd3,
        PAR_ONE    = 3'd4,
        PAR_IGNORE = 3'd5
    } par_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_TAIL
    } st_e;

    typedef struct packed {
        logic [3:0] dbits;
        par_e       par;
        logic [1:0] stops;
        logic       msb;
    } fmt_t;

    function automatic fmt_t make_fmt(logic [3:0] db, logic [2:0] pm,
                                      logic [1:0] sb, logic msb);
        fmt_t f;
        f.dbits = (db < 4'd5) ? 4'd5 : ((db > 4'd9) ? 4'd9 : db);
        f.par   = (pm > 3'd5) ? PAR_NONE : par_e'(pm);
        f.stops = (sb == 2'd3) ? 2'd2 : sb;
        f.msb   = msb;
        return f;
    endfunction

    function automatic logic [3:0] slot_count(fmt_t f);
        return 4'd1 + f.dbits + ((f.par != PAR_NONE) ? 4'd1 : 4'd0)
               + {2'b00, f.stops};
    endfunction

    function automatic logic parity_good(par_e m, logic [DMAX-1:0] d, logic p);
        case (m)
            PAR_ODD:  return (^d ^ p) == 1'b1;
            PAR_EVEN: return (^d ^ p) == 1'b0;
            PAR_ZERO: return p == 1'b0;
            PAR_ONE:  return p == 1'b1;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_linemon.sv
module uart_rx_linemon #(
    parameter int BRK_W = 20,
    parameter int FL_W  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl,
    input  logic             eng_idle,
    input  logic [FL_W-1:0]  flen,
    input  logic [BRK_W-1:0] brk_clks,
    output logic             brk_pulse,
    output logic             idle_pulse
);
    logic [BRK_W-1:0] low_cnt;
    logic [FL_W-1:0]  mark_cnt;
    logic             brk_hit, mark_run, idle_hit;

    assign brk_hit  = (brk_clks != '0) && !lvl && (low_cnt == brk_clks - 1'b1);
    assign mark_run = eng_idle && lvl;
    assign idle_hit = mark_run && (mark_cnt == flen - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt    <= '0;
            mark_cnt   <= '0;
            brk_pulse  <= 1'b0;
            idle_pulse <= 1'b0;
        end else begin
            if (lvl)                low_cnt <= '0;
            else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
            if (!mark_run || idle_hit) mark_cnt <= '0;
            else                       mark_cnt <= mark_cnt + 1'b1;
            brk_pulse  <= brk_hit;
            idle_pulse <= idle_hit;
        end
    end

    assert_brk_single_R9: assert property (@(posedge clk) disable iff (rst)
        brk_pulse |=> !brk_pulse);
    assert_idle_only_idle_R10: assert property (@(posedge clk) disable iff (rst)
        idle_pulse |-> $past(eng_idle) && $past(lvl));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int CPB_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl,
    input  logic             abort,
    input  fmt_t             cfg_fmt,
    input  logic [CPB_W-1:0] cfg_bw,
    input  logic [6:0]       cfg_pct,
    output logic             eng_idle,
    output logic             o_valid,
    output logic [DMAX-1:0]  o_data,
    output logic             o_ferr,
    output logic             o_perr
);
    localparam int PW = CPB_W + 7;

    st_e              st, st_n;
    fmt_t             fmt_q;
    logic [CPB_W-1:0] bw_q, off_q, bitcnt, off_c;
    logic [3:0]       slot, idx, idx_n, bpos;
    logic [DMAX-1:0]  sh, sh_n;
    logic             pe_q, pe_n, fe_q, fe_n, lvl_d;
    logic             samp, wrap, endf, fin, bad_start;
    logic [6:0]       pct_eff;
    logic [PW-1:0]    prod;

    // sample offset inside a slot, rounded up
    always_comb begin
        pct_eff = (cfg_pct >= 7'd1 && cfg_pct <= 7'd99) ? cfg_pct : 7'd50;
        prod    = PW'(cfg_bw - 1'b1) * PW'(pct_eff) + PW'(99);
        off_c   = CPB_W'(prod / PW'(100));
    end

    assign samp = (st != ST_IDLE) && (st != ST_TAIL) && (bitcnt == off_q);
    assign wrap = (bitcnt == bw_q - 1'b1);
    assign endf = wrap && (slot == slot_count(fmt_q) - 4'd1);
    assign bpos = fmt_q.msb ? (fmt_q.dbits - 4'd1 - idx) : idx;
    assign eng_idle = (st == ST_IDLE);

    always_comb begin
        st_n = st; idx_n = idx; sh_n = sh; pe_n = pe_q; fe_n = fe_q;
        fin = 1'b0; bad_start = 1'b0;
        case (st)
            ST_IDLE: if (!lvl && lvl_d) st_n = ST_START;
            ST_START: if (samp) begin
                if (lvl) begin
                    bad_start = 1'b1;
                    st_n = ST_IDLE;
                end else begin
                    st_n = ST_DATA; idx_n = '0; sh_n = '0;
                    pe_n = 1'b0; fe_n = 1'b0;
                end
            end
            ST_DATA: if (samp) begin
                sh_n[bpos] = lvl;
                idx_n = idx + 4'd1;
                if (idx == fmt_q.dbits - 4'd1) begin
                    idx_n = '0;
                    if (fmt_q.par != PAR_NONE) st_n = ST_PAR;
                    else if (fmt_q.stops != 2'd0) st_n = ST_STOP;
                    else fin = 1'b1;
                end
            end
            ST_PAR: if (samp) begin
                pe_n = !parity_good(fmt_q.par, sh, lvl);
                if (fmt_q.stops != 2'd0) st_n = ST_STOP;
                else fin = 1'b1;
            end
            ST_STOP: if (samp) begin
                if (!lvl) fe_n = 1'b1;
                idx_n = idx + 4'd1;
                if (idx == {2'b00, fmt_q.stops} - 4'd1) fin = 1'b1;
            end
            ST_TAIL: if (endf) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
        if (fin) st_n = endf ? ST_IDLE : ST_TAIL;
        if (abort) begin
            st_n = ST_IDLE; fin = 1'b0; bad_start = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; fmt_q <= '0; bw_q <= '0; off_q <= '0;
            bitcnt <= '0; slot <= '0; idx <= '0; sh <= '0;
            pe_q <= 1'b0; fe_q <= 1'b0; lvl_d <= 1'b0;
            o_valid <= 1'b0; o_data <= '0; o_ferr <= 1'b0; o_perr <= 1'b0;
        end else begin
            lvl_d <= lvl;
            st    <= st_n;
            idx   <= idx_n;
            sh    <= sh_n;
            pe_q  <= pe_n;
            fe_q  <= fe_n;
            if (st == ST_IDLE) begin
                fmt_q  <= cfg_fmt;
                bw_q   <= cfg_bw;
                off_q  <= off_c;
                bitcnt <= CPB_W'(1);
                slot   <= '0;
            end else begin
                bitcnt <= wrap ? '0 : bitcnt + 1'b1;
                if (wrap) slot <= slot + 4'd1;
            end
            o_valid <= fin;
            o_ferr  <= fin ? fe_n : bad_start;
            o_perr  <= fin & pe_n;
            if (fin) o_data <= sh_n;
        end
    end

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        o_valid |=> !o_valid);
    assert_perr_on_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        o_perr |-> o_valid);
    assert_reject_from_start_R3: assert property (@(posedge clk) disable iff (rst)
        (o_ferr && !o_valid) |-> $past(st) == ST_START);
    assert_fmt_held_R11: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(fmt_q) && $stable(bw_q));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int CPB_W       = 16,
    parameter int BRK_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_line,
    input  logic             cfg_invert,
    input  logic [CPB_W-1:0] cfg_clks_per_bit,
    input  logic [3:0]       cfg_data_bits,
    input  logic [2:0]       cfg_parity,
    input  logic [1:0]       cfg_stop_bits,
    input  logic             cfg_msb_first,
    input  logic [6:0]       cfg_sample_pct,
    input  logic [BRK_W-1:0] cfg_break_clks,
    output logic             rx_valid,
    output logic [8:0]       rx_data,
    output logic             rx_frame_err,
    output logic             rx_parity_err,
    output logic             brk_pulse,
    output logic             idle_pulse
);
    localparam int FL_W = CPB_W + 4;

    logic             line_s, lvl, eng_idle;
    fmt_t             fmt_live;
    logic [CPB_W-1:0] bw_eff;
    logic [FL_W-1:0]  flen;

    assign lvl      = line_s ^ cfg_invert;
    assign fmt_live = make_fmt(cfg_data_bits, cfg_parity, cfg_stop_bits, cfg_msb_first);
    assign bw_eff   = (cfg_clks_per_bit < CPB_W'(4)) ? CPB_W'(4) : cfg_clks_per_bit;
    assign flen     = FL_W'(slot_count(fmt_live)) * FL_W'(bw_eff);

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(rx_line), .q(line_s)
    );

    uart_rx_linemon #(.BRK_W(BRK_W), .FL_W(FL_W)) u_mon (
        .clk(clk), .rst(rst), .lvl(lvl), .eng_idle(eng_idle), .flen(flen),
        .brk_clks(cfg_break_clks), .brk_pulse(brk_pulse), .idle_pulse(idle_pulse)
    );

    uart_rx_frame #(.CPB_W(CPB_W)) u_frame (
        .clk(clk), .rst(rst), .lvl(lvl), .abort(brk_pulse), .cfg_fmt(fmt_live),
        .cfg_bw(bw_eff), .cfg_pct(cfg_sample_pct), .eng_idle(eng_idle),
        .o_valid(rx_valid), .o_data(rx_data), .o_ferr(rx_frame_err),
        .o_perr(rx_parity_err)
    );
endmodule

// File: tb/uart_frame_rx_tb.sv
module uart_frame_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic        cfg_invert = 1'b0;
    logic [15:0] cfg_clks_per_bit = 16'd8;
    logic [3:0]  cfg_data_bits = 4'd8;
    logic [2:0]  cfg_parity = 3'd0;
    logic [1:0]  cfg_stop_bits = 2'd1;
    logic        cfg_msb_first = 1'b0;
    logic [6:0]  cfg_sample_pct = 7'd50;
    logic [19:0] cfg_break_clks = 20'd0;
    logic        rx_valid, rx_frame_err, rx_parity_err, brk_pulse, idle_pulse;
    logic [8:0]  rx_data;

    int checks = 0, errors = 0;
    int vcnt = 0, fe_only = 0, bcnt = 0, icnt = 0, cyc = 0, it_prev = 0, it_last = 0;
    int last_data = 0, last_fe = 0, last_pe = 0;
    int bw_t = 8;

    always #4 clk = ~clk;

    uart_frame_rx u_dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .cfg_invert(cfg_invert),
        .cfg_clks_per_bit(cfg_clks_per_bit), .cfg_data_bits(cfg_data_bits),
        .cfg_parity(cfg_parity), .cfg_stop_bits(cfg_stop_bits),
        .cfg_msb_first(cfg_msb_first), .cfg_sample_pct(cfg_sample_pct),
        .cfg_break_clks(cfg_break_clks), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
        .brk_pulse(brk_pulse), .idle_pulse(idle_pulse)
    );

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (rx_valid) begin
                vcnt++; last_data = int'(rx_data);
                last_fe = int'(rx_frame_err); last_pe = int'(rx_parity_err);
            end
            if (rx_frame_err && !rx_valid) fe_only++;
            if (brk_pulse) bcnt++;
            if (idle_pulse) begin icnt++; it_prev = it_last; it_last = cyc; end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx_line = v ^ cfg_invert;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_fmt(input int d, input int pm, input int s, input int m);
        cfg_data_bits = 4'(d); cfg_parity = 3'(pm);
        cfg_stop_bits = 2'(s); cfg_msb_first = 1'(m);
    endtask

    function automatic logic exp_pbit(input int pm, input logic [8:0] v);
        case (pm)
            1: return ~(^v);
            2: return ^v;
            4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_frame(input logic [8:0] v, input int d, input logic has_p,
                              input logic pbit, input int s, input logic [1:0] stopv,
                              input logic msb);
        hold(1'b0, bw_t);
        for (int i = 0; i < d; i++) hold(msb ? v[d-1-i] : v[i], bw_t);
        if (has_p) hold(pbit, bw_t);
        for (int i = 0; i < s; i++) hold(stopv[i], bw_t);
        hold(1'b1, 2 * bw_t);
    endtask

    // slot 1 (data bit 0) is low for 10 clocks, then high
    task automatic split_frame(input int pct, input int expv, input string tag);
        int base;
        cfg_sample_pct = 7'(pct);
        base = vcnt;
        hold(1'b0, 16); hold(1'b0, 10); hold(1'b1, 6);
        hold(1'b0, 64); hold(1'b1, 16); hold(1'b1, 32);
        chk({tag, " strobe"}, vcnt - base, 1);
        chk({tag, " data"}, last_data, expv);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base, fbase, bbase, ibase;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk("R12 valid", int'(rx_valid), 0);
        chk("R12 data", int'(rx_data), 0);
        chk("R12 flags", int'(rx_frame_err) + int'(rx_parity_err) + int'(brk_pulse) + int'(idle_pulse), 0);
        hold(1'b1, 40);

        // R4 R5 R6 R7 sweep over every format
        for (int d = 5; d <= 9; d++)
            for (int pm = 0; pm <= 5; pm++)
                for (int s = 0; s <= 2; s++)
                    for (int m = 0; m < 2; m++) begin
                        logic [8:0] v;
                        v = 9'(d * 37 + pm * 11 + s * 5 + m * 3) & (9'h1ff >> (9 - d));
                        set_fmt(d, pm, s, m);
                        hold(1'b1, 4);
                        base = vcnt;
                        send_frame(v, d, pm != 0, exp_pbit(pm, v), s, 2'b11, 1'(m));
                        chk("R4 data", last_data, int'(v));
                        chk("R5 parity flag", last_pe, 0);
                        chk("R6 frame flag", last_fe, 0);
                        chk("R7 one strobe", vcnt - base, 1);
                    end

        // R5 wrong parity bits
        set_fmt(8, 1, 1, 0); send_frame(9'h5a, 8, 1, ~exp_pbit(1, 9'h5a), 1, 2'b11, 0);
        chk("R5 odd mismatch", last_pe, 1); chk("R5 data kept", last_data, 9'h5a);
        set_fmt(8, 2, 1, 0); send_frame(9'h5b, 8, 1, ~exp_pbit(2, 9'h5b), 1, 2'b11, 0);
        chk("R5 even mismatch", last_pe, 1);
        set_fmt(8, 3, 1, 0); send_frame(9'h11, 8, 1, 1'b1, 1, 2'b11, 0);
        chk("R5 zero mismatch", last_pe, 1);
        set_fmt(8, 4, 1, 0); send_frame(9'h12, 8, 1, 1'b0, 1, 2'b11, 0);
        chk("R5 one mismatch", last_pe, 1);
        set_fmt(8, 5, 1, 0); send_frame(9'h13, 8, 1, 1'b1, 1, 2'b11, 0);
        chk("R5 ignore high", last_pe, 0);
        send_frame(9'h14, 8, 1, 1'b0, 1, 2'b11, 0);
        chk("R5 ignore low", last_pe, 0);
        set_fmt(8, 7, 1, 0); send_frame(9'hc3, 8, 0, 1'b0, 1, 2'b11, 0);
        chk("R5 code 7 as none", last_data, 9'hc3); chk("R5 code 7 flag", last_fe, 0);

        // R6 stop slot errors
        set_fmt(8, 0, 1, 0); send_frame(9'h21, 8, 0, 0, 1, 2'b00, 0);
        chk("R6 single stop low", last_fe, 1); chk("R6 data kept", last_data, 9'h21);
        set_fmt(8, 0, 2, 0); send_frame(9'h22, 8, 0, 0, 2, 2'b10, 0);
        chk("R6 first stop low", last_fe, 1);
        send_frame(9'h23, 8, 0, 0, 2, 2'b01, 0);
        chk("R6 second stop low", last_fe, 1);
        set_fmt(8, 0, 3, 0); send_frame(9'h24, 8, 0, 0, 2, 2'b01, 0);
        chk("R6 code 3 as two stops", last_fe, 1);
        set_fmt(3, 0, 1, 0); send_frame(9'h1d, 5, 0, 0, 1, 2'b11, 0);
        chk("R4 width below 5 clamps", last_data, 9'h1d);

        // R3 rejected start
        set_fmt(8, 0, 1, 0);
        base = vcnt; fbase = fe_only;
        hold(1'b0, 2); hold(1'b1, 40);
        chk("R3 reject strobe", fe_only - fbase, 1);
        chk("R3 no data", vcnt - base, 0);

        // R8 glitch near frame end
        base = vcnt; fbase = fe_only;
        hold(1'b0, 8);
        for (int i = 0; i < 8; i++) hold(i[0], 8);
        hold(1'b1, 6); hold(1'b0, 1); hold(1'b1, 60);
        chk("R8 frame delivered", vcnt - base, 1);
        chk("R8 data", last_data, 9'haa);
        chk("R8 glitch ignored", fe_only - fbase, 0);

        // R2 sample point
        bw_t = 16; cfg_clks_per_bit = 16'd16; set_fmt(5, 0, 1, 0);
        split_frame(25, 0, "R2 pct 25");
        split_frame(75, 1, "R2 pct 75");
        split_frame(60, 0, "R2 pct 60");
        split_frame(66, 1, "R2 pct 66");
        split_frame(99, 1, "R2 pct 99");
        split_frame(1, 0, "R2 pct 1");
        split_frame(0, 0, "R2 pct 0 fallback");
        split_frame(120, 0, "R2 pct 120 fallback");
        cfg_sample_pct = 7'd50;

        // R13 bit times
        bw_t = 5; cfg_clks_per_bit = 16'd5; set_fmt(8, 2, 1, 1);
        send_frame(9'h96, 8, 1, exp_pbit(2, 9'h96), 1, 2'b11, 1);
        chk("R13 five clocks", last_data, 9'h96); chk("R13 five clocks flag", last_pe, 0);
        bw_t = 13; cfg_clks_per_bit = 16'd13;
        send_frame(9'h3c, 8, 1, exp_pbit(2, 9'h3c), 1, 2'b11, 1);
        chk("R13 thirteen clocks", last_data, 9'h3c);
        bw_t = 4; cfg_clks_per_bit = 16'd2;
        send_frame(9'h71, 8, 1, exp_pbit(2, 9'h71), 1, 2'b11, 1);
        chk("R13 clamp to four", last_data, 9'h71);

        // R11 format change mid-frame
        bw_t = 8; cfg_clks_per_bit = 16'd8; set_fmt(8, 0, 1, 0);
        hold(1'b1, 20);
        base = vcnt;
        hold(1'b0, 8);
        set_fmt(5, 2, 2, 1); cfg_clks_per_bit = 16'd12;
        for (int i = 0; i < 8; i++) hold(9'he5 >> i, 8);
        hold(1'b1, 8); hold(1'b1, 16);
        chk("R11 strobe", vcnt - base, 1);
        chk("R11 data", last_data, 9'he5);
        chk("R11 flags", last_fe + last_pe, 0);
        set_fmt(8, 0, 1, 0); cfg_clks_per_bit = 16'd8;

        // R1 inverted line
        cfg_invert = 1'b1; hold(1'b1, 60);
        base = vcnt; fbase = fe_only;
        send_frame(9'h4e, 8, 0, 0, 1, 2'b11, 0);
        chk("R1 inverted data", last_data, 9'h4e);
        chk("R1 inverted strobe", vcnt - base, 1);
        chk("R1 inverted no reject", fe_only - fbase, 0);
        cfg_invert = 1'b0; hold(1'b1, 60);

        // R9 break
        cfg_break_clks = 20'd200;
        base = vcnt; bbase = bcnt;
        hold(1'b0, 150); hold(1'b1, 60);
        chk("R9 short low no break", bcnt - bbase, 0);
        chk("R9 short low frame", vcnt - base, 1);
        chk("R9 short low frame err", last_fe, 1);
        bbase = bcnt;
        hold(1'b0, 400); hold(1'b1, 60);
        chk("R9 one break pulse", bcnt - bbase, 1);
        cfg_break_clks = 20'd40;
        base = vcnt; bbase = bcnt; fbase = fe_only;
        hold(1'b0, 60); hold(1'b1, 100);
        chk("R9 break aborts frame", vcnt - base, 0);
        chk("R9 abort pulse", bcnt - bbase, 1);
        chk("R9 abort no reject", fe_only - fbase, 0);
        cfg_break_clks = 20'd0;

        // R10 idle pulses
        ibase = icnt;
        hold(1'b1, 300);
        chk("R10 idle pulses seen", int'((icnt - ibase) >= 2), 1);
        chk("R10 idle spacing", it_last - it_prev, 80);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule